// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block is one output-compare channel. It watches the count of one of two external timers and drives a single output pin from two compare values. The pin goes high when the selected count equals the primary compare value. It goes low when the count equals the secondary compare value. The time between the two values sets the pulse position and width inside the timer period.

Software programs the channel through a small write port. Address 0 holds the control word, with the operating mode and the timer select. Addresses 1 and 2 hold the primary and secondary compare values. Address 3 is a write-one-to-clear port for the event flag. There are two working modes:
- **One-shot** gives exactly one pulse and is re-armed by writing the mode again.
- **Continuous** gives one pulse in every timer period.

Each falling-edge match sets a sticky flag. That flag becomes an interrupt request when the enable input is high.

Each timer supplies a count and a tick strobe. The tick marks the cycle in which the count has just taken a new value. Compares are only evaluated on ticks, so a stalled timer never retriggers the channel.

Top module: `dual_cmp_pulse`

## Requirements
- R1: After a synchronous reset, pin_out, flag_out and irq_out are 0, the mode is 3'b000 and both compare values are 0.
- R2: A write with wr_sel=0 loads mode from wr_data[2:0] and timer select from wr_data[3]. It drives pin_out low on the next cycle whatever the channel was doing. Mode 3'b100 or 3'b101 also arms the channel to wait for a primary match.
- R3: An armed channel that is waiting drives pin_out high one cycle after a cycle in which the selected tick is 1 and the selected count equals the primary value (loaded by wr_sel=1).
- R4: A high pin goes low one cycle after a cycle in which the selected tick is 1 and the count equals the secondary value (loaded by wr_sel=2). Secondary matches while the pin is low are ignored, and so are primary matches while it is high.
- R5: In mode 3'b100, the pin stays low after the falling edge until the control word is written again with 3'b100. No channel disable is needed before that write.
- R6: In mode 3'b101, the channel re-arms at each falling edge, giving one pulse per timer period.
- R7: Timer select 0 compares tmr_a_cnt/tmr_a_tick and select 1 compares tmr_b_cnt/tmr_b_tick. The unselected timer has no effect on the pin.
- R8: When the selected tick is 0, the pin does not change, except through a control write, even if the count equals a compare value.
- R9: flag_out goes to 1 one cycle after every falling-edge match. It stays 1 until a write with wr_sel=3 and wr_data[0]=1. If a fall and a clear happen in the same cycle, the flag ends up set.
- R10: irq_out after an edge equals flag_out after that edge ANDed with irq_en sampled at that edge.
- R11: Mode 3'b000, and every mode value other than 3'b100 and 3'b101, disables the channel. The pin stays low and matches do not set the flag.
- R12: Writing a compare value leaves the pin and the channel state unchanged. The new value is used for compares from the next cycle.
- R13: If a control write and a match fall in the same cycle, the control write wins and the match is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 primary, 2 secondary, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| tmr_a_cnt | input | CNT_W | Count of timer A |
| tmr_a_tick | input | 1 | Timer A count has just advanced |
| tmr_b_cnt | input | CNT_W | Count of timer B |
| tmr_b_tick | input | 1 | Timer B count has just advanced |
| irq_en | input | 1 | Interrupt request enable |
| pin_out | output | 1 | Compare output pin |
| flag_out | output | 1 | Sticky falling-edge event flag |
| irq_out | output | 1 | Interrupt request |

## Verification
The directed patterns and what each one distinguishes:
- **One-shot run with a fast timer.** Separates one-shot from continuous behaviour by counting rising edges over several periods. It also checks the pulse width against the primary-to-secondary distance.
- **Re-write of mode 3'b100.** Shows that a re-arm needs no disable.
- **Continuous run over a known number of ticks.** Must give exactly one pulse per period.
- **Timer frozen on a compare value.** Separates tick-qualified compares from plain equality.
- **Timer B selected while timer A is frozen.** Proves which count is compared.
- **Illegal mode value.** Must behave as disabled.

Long random sequences then follow. They mix:
- writes landing on match cycles;
- timers with irregular ticks;
- compare values that change mid-pulse.

A bench reference model predicts the pin, flag and interrupt in every cycle, which separates write priority and flag set/clear ordering from the plain compare path.

// File: rtl/dcp_pkg.sv
`timescale 1ns/1ps
package dcp_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } dcp_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRI  = 2'd1;
  localparam logic [1:0] ADDR_SEC  = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  localparam logic [2:0] MODE_ONCE = 3'b100;
  localparam logic [2:0] MODE_CONT = 3'b101;

  localparam int TSEL_LSB = 3;

  function automatic logic mode_active(input logic [2:0] m);
    return (m == MODE_ONCE) || (m == MODE_CONT);
  endfunction

endpackage

// File: rtl/dcp_regs.sv
`timescale 1ns/1ps
module dcp_regs
  import dcp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [2:0]       mode_q,
  output logic [SEL_W-1:0] tsel_q,
  output logic [CNT_W-1:0] pri_q,
  output logic [CNT_W-1:0] sec_q,
  output logic             ctrl_wr,
  output logic             flag_clr
);

  assign ctrl_wr  = wr_en && (wr_sel == ADDR_CTRL);
  assign flag_clr = wr_en && (wr_sel == ADDR_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tsel_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        ADDR_CTRL: begin
          mode_q <= wr_data[2:0];
          tsel_q <= wr_data[TSEL_LSB +: SEL_W];
        end
        ADDR_PRI: pri_q <= wr_data;
        ADDR_SEC: sec_q <= wr_data;
        default:  ;
      endcase
    end
  end

  // R12
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != ADDR_PRI) |=> $stable(pri_q));

endmodule

// File: rtl/dcp_tsel.sv
`timescale 1ns/1ps
module dcp_tsel #(
  parameter int CNT_W   = 16,
  parameter int NUM_TMR = 2,
  localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NUM_TMR-1:0]            tick_vec,
  input  logic [SEL_W-1:0]              sel,
  output logic [CNT_W-1:0]              cnt,
  output logic                          tick
);

  always_comb begin
    cnt  = '0;
    tick = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel == SEL_W'(i)) begin
        cnt  = cnt_vec[i];
        tick = tick_vec[i];
      end
    end
  end

endmodule

// File: rtl/dcp_match.sv
`timescale 1ns/1ps
module dcp_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic [CNT_W-1:0] pri,
  input  logic [CNT_W-1:0] sec,
  output logic             hit_pri,
  output logic             hit_sec
);

  assign hit_pri = tick && (cnt == pri);
  assign hit_sec = tick && (cnt == sec);

endmodule

// File: rtl/dcp_fsm.sv
`timescale 1ns/1ps
module dcp_fsm
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [2:0] new_mode,
  input  logic [2:0] mode_q,
  input  logic       hit_pri,
  input  logic       hit_sec,
  input  logic       tick,
  input  logic       flag_clr,
  input  logic       irq_en,
  output logic       pin_q,
  output logic       flag_q,
  output logic       irq_q
);

  dcp_state_e st_q, st_d;
  logic pin_d, flag_d, fall;

  always_comb begin
    st_d  = st_q;
    pin_d = pin_q;
    fall  = 1'b0;
    if (ctrl_wr) begin
      pin_d = 1'b0;
      st_d  = mode_active(new_mode) ? ST_WAIT : ST_OFF;
    end else begin
      case (st_q)
        ST_WAIT: if (hit_pri) begin
          pin_d = 1'b1;
          st_d  = ST_HIGH;
        end
        ST_HIGH: if (hit_sec) begin
          pin_d = 1'b0;
          fall  = 1'b1;
          st_d  = (mode_q == MODE_CONT) ? ST_WAIT : ST_DONE;
        end
        default: ;
      endcase
    end
    flag_d = fall | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OFF;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pin_q  <= pin_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

  // R2
  ctrl_low_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !pin_q);

  // R5
  once_done_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && !ctrl_wr) |=> !pin_q);

  // R8
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrl_wr) |=> $stable(pin_q));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HIGH && hit_sec && !ctrl_wr) |=> flag_q);

  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);

  // R11
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_active(mode_q) |=> !pin_q);

endmodule

// File: rtl/dual_cmp_pulse.sv
`timescale 1ns/1ps
module dual_cmp_pulse #(
  parameter int CNT_W   = 16,
  localparam int NUM_TMR = 2,
  localparam int SEL_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] tmr_a_cnt,
  input  logic             tmr_a_tick,
  input  logic [CNT_W-1:0] tmr_b_cnt,
  input  logic             tmr_b_tick,
  input  logic             irq_en,
  output logic             pin_out,
  output logic             flag_out,
  output logic             irq_out
);

  logic [2:0]       mode_q;
  logic [SEL_W-1:0] tsel_q;
  logic [CNT_W-1:0] pri_q, sec_q, cnt_s;
  logic             ctrl_wr, flag_clr, tick_s, hit_pri, hit_sec;

  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_TMR-1:0]            tick_vec;

  assign cnt_vec  = {tmr_b_cnt, tmr_a_cnt};
  assign tick_vec = {tmr_b_tick, tmr_a_tick};

  dcp_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_q(mode_q), .tsel_q(tsel_q), .pri_q(pri_q), .sec_q(sec_q),
    .ctrl_wr(ctrl_wr), .flag_clr(flag_clr)
  );

  dcp_tsel #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) u_tsel (
    .cnt_vec(cnt_vec), .tick_vec(tick_vec), .sel(tsel_q),
    .cnt(cnt_s), .tick(tick_s)
  );

  dcp_match #(.CNT_W(CNT_W)) u_match (
    .cnt(cnt_s), .tick(tick_s), .pri(pri_q), .sec(sec_q),
    .hit_pri(hit_pri), .hit_sec(hit_sec)
  );

  dcp_fsm u_fsm (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .new_mode(wr_data[2:0]),
    .mode_q(mode_q), .hit_pri(hit_pri), .hit_sec(hit_sec), .tick(tick_s),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .pin_q(pin_out), .flag_q(flag_out), .irq_q(irq_out)
  );

  // R7
  unsel_tmr_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel_q == 1'b0 && !tmr_a_tick && !ctrl_wr) |=> $stable(pin_out));

endmodule

// File: tb/dual_cmp_pulse_bench.sv
`timescale 1ns/1ps
module dual_cmp_pulse_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] tmr_a_cnt = '0, tmr_b_cnt = '0;
  logic             tmr_a_tick = 1'b0, tmr_b_tick = 1'b0;
  logic             irq_en = 1'b0;
  logic             pin_out, flag_out, irq_out;

  always #10 clk = ~clk;

  dual_cmp_pulse #(.CNT_W(CNT_W)) u_dual_cmp_pulse (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tmr_a_cnt(tmr_a_cnt), .tmr_a_tick(tmr_a_tick),
    .tmr_b_cnt(tmr_b_cnt), .tmr_b_tick(tmr_b_tick),
    .irq_en(irq_en), .pin_out(pin_out), .flag_out(flag_out), .irq_out(irq_out)
  );

  int checks = 0, errors = 0, rises = 0, hi_cycles = 0;
  bit done = 1'b0, prev_pin = 1'b0;
  string cur_req = "R13";

  // bench timers
  int ta_per = 15, tb_per = 20, ta_rate = 100, tb_rate = 0;
  int ta_c = 0, tb_c = 0;

  // reference model
  bit [2:0]       m_mode = 0;
  bit             m_sel = 0;
  bit [CNT_W-1:0] m_pri = 0, m_sec = 0;
  int             m_st = 0;
  bit             m_pin = 0, m_flag = 0, m_irq = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int next_cnt(input int c, input int per);
    return (c >= per) ? 0 : c + 1;
  endfunction

  task automatic model_step(input bit we, input bit [1:0] ws, input bit [CNT_W-1:0] wd,
                            input int cs, input bit ts, input bit en);
    bit fall = 0;
    if (we && ws == 2'd0) begin
      m_pin = 0;
      m_st  = (wd[2:0] == 3'b100 || wd[2:0] == 3'b101) ? 1 : 0;
    end else if (m_st == 1) begin
      if (ts && cs == int'(m_pri)) begin m_pin = 1; m_st = 2; end
    end else if (m_st == 2) begin
      if (ts && cs == int'(m_sec)) begin
        m_pin = 0; fall = 1; m_st = (m_mode == 3'b101) ? 1 : 3;
      end
    end
    if (fall) m_flag = 1;
    else if (we && ws == 2'd3 && wd[0]) m_flag = 0;
    m_irq = m_flag & en;
    if (we) begin
      case (ws)
        2'd0: begin m_mode = wd[2:0]; m_sel = wd[3]; end
        2'd1: m_pri = wd;
        2'd2: m_sec = wd;
        default: ;
      endcase
    end
  endtask

  // one cycle: compare at negedge, drive next inputs, advance to next negedge
  task automatic cyc(input bit we, input bit [1:0] ws, input bit [CNT_W-1:0] wd);
    bit ta, tb;
    check(cur_req, "pin", int'(pin_out), int'(m_pin));
    check(cur_req, "flag", int'(flag_out), int'(m_flag));
    check(cur_req, "irq", int'(irq_out), int'(m_irq));
    if (pin_out && !prev_pin) rises++;
    if (pin_out) hi_cycles++;
    prev_pin = pin_out;
    ta = ($urandom % 100) < ta_rate;
    tb = ($urandom % 100) < tb_rate;
    if (ta) ta_c = next_cnt(ta_c, ta_per);
    if (tb) tb_c = next_cnt(tb_c, tb_per);
    tmr_a_cnt = CNT_W'(ta_c); tmr_a_tick = ta;
    tmr_b_cnt = CNT_W'(tb_c); tmr_b_tick = tb;
    wr_en = we; wr_sel = ws; wr_data = wd;
    model_step(we, ws, wd, m_sel ? tb_c : ta_c, m_sel ? tb : ta, irq_en);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, '0);
  endtask

  task automatic wr(input bit [1:0] ws, input bit [CNT_W-1:0] wd);
    cyc(1, ws, wd);
  endtask

  initial begin
    void'($urandom(32'h1d5c_07a3));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "pin", int'(pin_out), 0);
    check("R1", "flag", int'(flag_out), 0);
    check("R1", "irq", int'(irq_out), 0);

    // R3 R4 R5: one-shot, fast timer A, pri 5 sec 9
    cur_req = "R3";
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd9);
    rises = 0; hi_cycles = 0;
    wr(2'd0, 16'h0004);
    idle(60);
    check("R5", "one-shot pulse count", rises, 1);
    check("R4", "pulse width", hi_cycles, 4);
    check("R9", "flag after fall", int'(flag_out), 1);

    // R5 re-arm without disable
    cur_req = "R5";
    rises = 0;
    wr(2'd0, 16'h0004);
    idle(40);
    check("R5", "re-arm pulse count", rises, 1);

    // R6 continuous: exactly one pulse per 16-tick period
    cur_req = "R6";
    wr(2'd3, 16'd1);
    rises = 0;
    wr(2'd0, 16'h0005);
    idle(65);
    check("R6", "continuous pulse count", rises, 4);

    // R12 compare write while high, R2 forced low
    cur_req = "R12";
    while (!pin_out) idle(1);
    wr(2'd1, 16'd12);
    check("R12", "pin after compare write", int'(pin_out), 1);
    cur_req = "R2";
    wr(2'd0, 16'h0005);
    check("R2", "pin after control write", int'(pin_out), 0);

    // R9 R10: freeze timer, test flag and irq gating
    cur_req = "R10";
    while (!flag_out) idle(1);
    ta_rate = 0;
    irq_en = 1'b0;
    idle(2);
    check("R10", "irq masked", int'(irq_out), 0);
    irq_en = 1'b1;
    idle(2);
    check("R10", "irq enabled", int'(irq_out), 1);
    idle(3);
    check("R9", "flag sticky", int'(flag_out), 1);
    wr(2'd3, 16'd1);
    check("R9", "flag cleared", int'(flag_out), 0);
    check("R10", "irq cleared", int'(irq_out), 0);

    // R8 stalled timer sitting on primary value
    cur_req = "R8";
    wr(2'd1, CNT_W'(ta_c));
    rises = 0;
    wr(2'd0, 16'h0005);
    idle(10);
    check("R8", "no rise without tick", rises, 0);

    // R7 timer B selected, timer A frozen
    cur_req = "R7";
    tb_rate = 60;
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd7);
    rises = 0;
    wr(2'd0, 16'h000D);
    idle(120);
    check("R7", "timer B pulses", int'(rises > 1), 1);

    // R11 illegal mode disables
    cur_req = "R11";
    ta_rate = 100;
    wr(2'd0, 16'h0007);
    wr(2'd3, 16'd1);
    rises = 0;
    idle(50);
    check("R11", "no pulses when disabled", rises, 0);
    check("R11", "no flag when disabled", int'(flag_out), 0);

    // R13 random traffic against model
    cur_req = "R13";
    ta_per = 31; tb_per = 23;
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      if (i % 400 == 0) begin
        ta_rate = 30 + $urandom % 71;
        tb_rate = 30 + $urandom % 71;
        irq_en = $urandom % 2;
      end
      if (r < 3) begin
        bit [2:0] md;
        case ($urandom % 5)
          0: md = 3'b000; 1, 2: md = 3'b101; 3: md = 3'b100; default: md = 3'($urandom);
        endcase
        wr(2'd0, {12'd0, 1'($urandom), md});
      end else if (r < 6) wr(2'd1, CNT_W'($urandom % 32));
      else if (r < 9) wr(2'd2, CNT_W'($urandom % 32));
      else if (r < 11) wr(2'd3, CNT_W'($urandom % 2));
      else idle(1);
    end
    idle(1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule